// File: doc/BRIEF.md
# Protected Clock Synthesizer Configuration Unit

This block is the digital front end of an on-chip clock multiplier. Software writes an enable/connect control word and a multiplier/divider configuration word into staging registers. Neither write has any effect on the synthesizer until it is confirmed by a two-write unlock feed. The feed guards against a stray store silently retuning or disconnecting the chip clock.

At the moment of confirmation, the staged multiplier and divider pair is checked against the legal output-clock window and the legal internal-oscillator window. The check uses the reference frequency given as a parameter. A legal pair is passed to the analog loop. An illegal pair is refused: the previous pair stays active and an error flag is raised.

The output is switched onto the synthesized clock only while the loop is enabled, connection is requested and the analog loop reports lock. Because the smallest post-divider is 2, the delivered clock always has an even duty cycle.

Top module: `clk_synth_guard`

## Requirements
- R1: After reset, en_o=0, connect_o=0, mult_o=0 (multiplier 1), dsel_o=0 (divide by 2) and cfg_err_o=0.
- R2: A write to the control word (address 0) or the configuration word (address 1) changes no output until a feed completes.
- R3: A write of 0xAA to the feed address (address 2), followed on the next bus write by 0x55 to the feed address, commits the staged words at that second write's clock edge. Idle cycles between the two writes are allowed. A 0x55 without a preceding 0xAA commits nothing.
- R4: Any other bus write while armed aborts the feed. This includes a register write, a wrong feed byte and a repeated 0xAA. The aborting write is not stored, and the staged words are reloaded from the active values, so a later good feed changes nothing.
- R5: Configuration word encoding: bits 4:0 hold the multiplier minus one (1..32), and bits 6:5 select the post-divider (0→2, 1→4, 2→8, 3→16). mult_o and dsel_o present the active values in that same encoding.
- R6: A staged pair is legal only when REF_KHZ×M lies in 10000..60000 kHz and REF_KHZ×M×D lies in 156000..320000 kHz, with the limits inclusive.
- R7: A commit with an illegal pair sets cfg_err_o and keeps the previous mult_o/dsel_o, although the control word still commits. A commit with a legal pair clears cfg_err_o.
- R8: Control word encoding: bit 0 is enable and bit 1 is connect. en_o shows the active enable. connect_o is high only while the active enable, the active connect and lock_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe, one access per cycle |
| addr_i | input | 2 | Register address: 0 control, 1 configuration, 2 feed |
| wdata_i | input | 8 | Write data |
| lock_i | input | 1 | Lock indication from the analog loop |
| en_o | output | 1 | Active loop enable |
| connect_o | output | 1 | Synthesized clock selected as system clock |
| mult_o | output | 5 | Active multiplier minus one |
| dsel_o | output | 2 | Active post-divider select |
| cfg_err_o | output | 1 | Last committed configuration was refused |

## Verification
The bench breaks the feed in each way a careless state machine might miss:
- an unpaired 0x55;
- a wrong second byte;
- a register write in the middle;
- a doubled 0xAA.

A design that failed to discard the staged words would apply them on the next clean feed. The bench drives pairs that sit exactly on the 60 MHz output limit. It also drives pairs that fail only the oscillator window, either too low or too high. A design that swapped the divider encoding, or tested only one window, would accept or refuse the wrong pair. Lock is toggled with enable off and on, to catch a connect output that ignores either gate.

// File: rtl/csu_pkg.sv
package csu_pkg;
    // Field widths of the configuration word.
    localparam int MULT_W = 5;
    localparam int DSEL_W = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // Register addresses.
    localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FEED = 2'd2;

    // Unlock bytes, in the order they must arrive.
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

    typedef struct packed {
        logic [DSEL_W-1:0] dsel;
        logic [MULT_W-1:0] mraw;
    } syn_cfg_t;

    typedef struct packed {
        logic conn;
        logic en;
    } syn_ctl_t;
endpackage

// File: rtl/csu_feed_seq.sv
// Unlock sequencer. It arms on a first-key feed write and fires commit
// when the very next bus write is the second key to the feed address.
// Any other write while armed raises abort. Assumes one bus write per cycle.
module csu_feed_seq
    import csu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              is_feed_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              armed_o,
    output logic              commit_o,
    output logic              abort_o
);
    logic armed_q;

    // Armed state: set by a first key when idle, cleared by any write when armed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (acc_i)
            armed_q <= !armed_q && is_feed_i && (data_i == KEY_FIRST);
    end

    // Outcome of the write that follows the first key.
    always_comb begin
        commit_o = armed_q && acc_i && is_feed_i && (data_i == KEY_SECOND);
        abort_o  = armed_q && acc_i && !commit_o;
    end

    assign armed_o = armed_q;

    // Armed state lasts at most until the next write (R4).
    p_arm_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && acc_i) |=> !armed_q);
endmodule

// File: rtl/csu_range_check.sv
// Frequency window check for one multiplier/divider pair.
// Assumes REF_KHZ is itself a legal reference (10000..25000 kHz).
// Arithmetic is 32 bits wide, which is ample for 25000 x 32 x 16.
module csu_range_check
    import csu_pkg::*;
#(
    parameter int REF_KHZ = 12000,
    parameter int OUT_MIN = 10000,
    parameter int OUT_MAX = 60000,
    parameter int OSC_MIN = 156000,
    parameter int OSC_MAX = 320000
) (
    input  syn_cfg_t cfg_i,
    output logic     ok_o
);
    logic [31:0] mult_v, div_v, out_v, osc_v;

    // Decode the pair, then derive output and oscillator frequencies in kHz.
    always_comb begin
        mult_v = 32'(cfg_i.mraw) + 32'd1;
        div_v  = 32'd2 << cfg_i.dsel;
        out_v  = 32'(REF_KHZ) * mult_v;
        osc_v  = out_v * div_v;
        ok_o   = (out_v >= 32'(OUT_MIN)) && (out_v <= 32'(OUT_MAX)) &&
                 (osc_v >= 32'(OSC_MIN)) && (osc_v <= 32'(OSC_MAX));
    end
endmodule

// File: rtl/clk_synth_guard.sv
// Protected configuration unit for a clock multiplier.
// Bus writes land in staging registers. A completed feed copies them to the
// active registers, and an illegal multiplier/divider pair is refused.
// Assumes single-cycle writes with no read path; the active state is on ports.
module clk_synth_guard
    import csu_pkg::*;
#(
    parameter int REF_KHZ = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              lock_i,
    output logic              en_o,
    output logic              connect_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [DSEL_W-1:0] dsel_o,
    output logic              cfg_err_o
);
    localparam int CFG_W = MULT_W + DSEL_W;

    syn_ctl_t stg_ctl, act_ctl;
    syn_cfg_t stg_cfg, act_cfg;
    logic     err_q;
    logic     armed, commit, abort;
    logic     stg_ok, act_ok;

    csu_feed_seq u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (wr_en_i),
        .is_feed_i (addr_i == A_FEED),
        .data_i    (wdata_i),
        .armed_o   (armed),
        .commit_o  (commit),
        .abort_o   (abort)
    );

    csu_range_check #(.REF_KHZ(REF_KHZ)) u_chk_stg (
        .cfg_i (stg_cfg),
        .ok_o  (stg_ok)
    );

    csu_range_check #(.REF_KHZ(REF_KHZ)) u_chk_act (
        .cfg_i (act_cfg),
        .ok_o  (act_ok)
    );

    // Staging registers: take idle-time writes, reload on abort or commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ctl <= '0;
            stg_cfg <= '0;
        end else if (abort) begin
            stg_ctl <= act_ctl;
            stg_cfg <= act_cfg;
        end else if (commit) begin
            if (!stg_ok)
                stg_cfg <= act_cfg;
        end else if (wr_en_i && !armed) begin
            if (addr_i == A_CTL)
                stg_ctl <= syn_ctl_t'(wdata_i[1:0]);
            else if (addr_i == A_CFG)
                stg_cfg <= syn_cfg_t'(wdata_i[CFG_W-1:0]);
        end
    end

    // Active registers and error flag: updated only by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctl <= '0;
            act_cfg <= '0;
            err_q   <= 1'b0;
        end else if (commit) begin
            act_ctl <= stg_ctl;
            if (stg_ok) begin
                act_cfg <= stg_cfg;
                err_q   <= 1'b0;
            end else begin
                err_q   <= 1'b1;
            end
        end
    end

    // Output drive; the clock is selected only when locked and enabled.
    always_comb begin
        en_o      = act_ctl.en;
        connect_o = act_ctl.en && act_ctl.conn && lock_i;
        mult_o    = act_cfg.mraw;
        dsel_o    = act_cfg.dsel;
        cfg_err_o = err_q;
    end

    // Active pair moves only on a commit (R3).
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_cfg));

    // Control word moves only on a commit (R2).
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_ctl));

    // Any new active pair lies inside both windows (R6).
    p_cfg_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> act_ok);

    // A refused pair leaves the active pair alone and flags it (R7).
    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !stg_ok) |=> ($stable(act_cfg) && cfg_err_o));

    // Connection requires enable and lock (R8).
    p_connect_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        connect_o |-> (en_o && lock_i));
endmodule

// File: tb/clk_synth_guard_test.sv
module clk_synth_guard_test;
    localparam int REF = 12000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       lock = 1'b0;
    logic       en_o, connect_o, cfg_err_o;
    logic [4:0] mult_o;
    logic [1:0] dsel_o;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    // Bench-side model of the active configuration.
    int exp_m = 1;
    int exp_sel = 0;
    bit exp_err = 1'b0;

    always #2.5 clk = ~clk;

    clk_synth_guard #(.REF_KHZ(REF)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .lock_i(lock), .en_o(en_o), .connect_o(connect_o),
        .mult_o(mult_o), .dsel_o(dsel_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic bit legal(input int m, input int sel);
        int outf = REF * m;
        int osc = outf * (2 << sel);
        return (outf >= 10000) && (outf <= 60000) && (osc >= 156000) && (osc <= 320000);
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic feed();
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'h55);
    endtask

    function automatic logic [7:0] cfg_word(input int m, input int sel);
        logic [4:0] mr = 5'(m - 1);
        logic [1:0] s = 2'(sel);
        return {1'b0, s, mr};
    endfunction

    task automatic check_cfg(input string req);
        check(mult_o == 5'(exp_m - 1), req, int'(mult_o), exp_m - 1);
        check(dsel_o == 2'(exp_sel), req, int'(dsel_o), exp_sel);
        check(cfg_err_o == exp_err, req, int'(cfg_err_o), int'(exp_err));
    endtask

    // Stage a pair, commit it, and track the expected outcome (R5, R6, R7).
    task automatic try_pair(input int m, input int sel, input string req);
        bus_wr(2'd1, cfg_word(m, sel));
        feed();
        if (legal(m, sel)) begin
            exp_m = m; exp_sel = sel; exp_err = 1'b0;
        end else begin
            exp_err = 1'b1;
        end
        check_cfg(req);
    endtask

    task automatic t_reset();
        check(en_o == 1'b0, "R1", int'(en_o), 0);
        check(connect_o == 1'b0, "R1", int'(connect_o), 0);
        check_cfg("R1");
    endtask

    task automatic t_no_feed();
        bus_wr(2'd1, cfg_word(5, 1));
        bus_wr(2'd0, 8'h03);
        check(en_o == 1'b0, "R2", int'(en_o), 0);
        check_cfg("R2");
    endtask

    task automatic t_commit();
        bus_wr(2'd2, 8'h55);
        check_cfg("R3 lone second key");
        check(en_o == 1'b0, "R3 lone second key", int'(en_o), 0);
        bus_wr(2'd2, 8'hAA);
        repeat (3) @(negedge clk);
        bus_wr(2'd2, 8'h55);
        exp_m = 5; exp_sel = 1;
        check_cfg("R3 R5 commit at 60 MHz edge");
        check(en_o == 1'b1, "R3 R8 enable", int'(en_o), 1);
    endtask

    task automatic t_reject();
        bus_wr(2'd0, 8'h00);
        try_pair(6, 1, "R7 output too fast");
        check(en_o == 1'b0, "R7 control still commits", int'(en_o), 1'b0);
        try_pair(4, 1, "R7 legal clears flag");
    endtask

    task automatic t_abort();
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd1, cfg_word(1, 3));
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd2, 8'h55);
        check(en_o == 1'b0, "R4 reg write aborts", int'(en_o), 0);
        feed();
        check(en_o == 1'b0, "R4 staged discarded", int'(en_o), 0);
        check_cfg("R4 staged discarded");
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'h12);
        bus_wr(2'd2, 8'h55);
        check(en_o == 1'b0, "R4 wrong byte", int'(en_o), 0);
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'h55);
        check(en_o == 1'b0, "R4 doubled first key", int'(en_o), 0);
    endtask

    task automatic t_windows();
        try_pair(1, 3, "R6 divide16 legal");
        try_pair(1, 2, "R6 osc too low");
        try_pair(2, 3, "R6 osc too high");
        try_pair(16, 0, "R6 output too fast");
        try_pair(13, 0, "R6 output too fast");
        try_pair(2, 2, "R5 R6 divide8 legal");
        try_pair(32, 3, "R5 max multiplier");
        try_pair(3, 2, "R6 legal");
    endtask

    task automatic t_connect();
        bus_wr(2'd0, 8'h03);
        feed();
        lock = 1'b0;
        @(negedge clk);
        check(connect_o == 1'b0, "R8 no lock", int'(connect_o), 0);
        lock = 1'b1;
        @(negedge clk);
        check(connect_o == 1'b1, "R8 locked", int'(connect_o), 1);
        bus_wr(2'd0, 8'h02);
        feed();
        check(connect_o == 1'b0, "R8 enable off", int'(connect_o), 0);
        bus_wr(2'd0, 8'h01);
        feed();
        check(connect_o == 1'b0, "R8 connect off", int'(connect_o), 0);
        check(en_o == 1'b1, "R8 enable bit0", int'(en_o), 1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_feed();
        t_commit();
        t_reject();
        t_abort();
        t_windows();
        t_connect();
        report();
    end
endmodule